// File: doc/BRIEF.md
# Dual-channel bus-master DMA register window

This block is the host-visible register file of a two-channel disk bus-master DMA engine. A 16-byte I/O window is split into one 8-byte slice per channel. Each slice holds a command byte, a status byte and a 32-bit descriptor-table pointer. The host reaches the window through a byte-addressed request port that carries an access size. The DMA engine reads the command bits and the pointer from the block and reports progress back by pulsing per-channel active, error and interrupt inputs.

The command/status half of each slice accepts only single-byte accesses. Wider accesses there are dropped on write and read back as all ones. The status byte mixes three kinds of bit: plain read/write flags, write-one-to-clear event flags and a read-only active flag. The pointer half accepts byte, 16-bit and 32-bit accesses and always stays dword aligned. Data on the host port is right-justified: a byte uses bits 7:0 and a 16-bit access uses bits 15:0.

Top module: `bmdma_regs`

## Requirements
- R1: After reset, the command, status and pointer registers of both channels read as zero, and irq_o, cmd_start_o and cmd_dir_o are low.
- R2: Address bit 3 selects the channel (0 = offsets 0..7, 1 = offsets 8..15). Within a slice, offset +0 is the command register, offset +2 is the status register and offsets +4..+7 are the pointer. An access to one channel never changes the other.
- R3: A byte read at slice offset +1 or +3 returns 0x000000FF. A byte write to either offset changes no register.
- R4: A read of the command/status sub-window whose size_i is not byte (0) returns all ones across the access width: 0x0000FFFF for 16-bit (size_i=1) and 0xFFFFFFFF for 32-bit (size_i=2 or 3).
- R5: A write of the command/status sub-window whose size_i is not byte is discarded.
- R6: A byte write to the command register stores bit 0 (start, driven on cmd_start_o) and bit 3 (direction, driven on cmd_dir_o). All other command bits read as zero.
- R7: A byte write of value w to the status register sets bits 6:5 to w[6:5] and leaves bit 0 unchanged. Bits 1 and 2 are cleared where w has a 1 and kept where w has a 0. All other status bits read as zero.
- R8: Per channel, set_active_i sets status bit 0 and clr_active_i clears it; set wins if both are asserted. set_error_i sets bit 1 and set_irq_i sets bit 2. A hardware set wins over a host write-one-to-clear in the same cycle.
- R9: The pointer takes byte writes (one lane), 16-bit writes (lanes 1:0 at offset +4, lanes 3:2 at offset +6) and 32-bit writes. Bits 1:0 always read as zero. Reads return the addressed bytes right-justified and masked to the access width.
- R10: irq_o of a channel is high exactly while that channel's status bit 2 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Host access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 4 | Byte offset in the window |
| size_i | input | 2 | 0 byte, 1 16-bit, 2/3 32-bit |
| wdata_i | input | 32 | Right-justified write data |
| rdata_o | output | 32 | Read data (combinational, zero when no read) |
| set_active_i | input | 2 | Per channel: set active flag |
| clr_active_i | input | 2 | Per channel: clear active flag |
| set_error_i | input | 2 | Per channel: set error flag |
| set_irq_i | input | 2 | Per channel: set interrupt flag |
| cmd_start_o | output | 2 | Per channel command start bit |
| cmd_dir_o | output | 2 | Per channel command direction bit |
| ptr_o | output | 64 | Descriptor pointers, channel 0 in bits 31:0 |
| irq_o | output | 2 | Per channel interrupt request |

## Verification
The assertions check the following on every cycle: the active flag holds when no hardware request arrives, hardware error and interrupt sets always land, a host clear of the interrupt flag takes effect when no set competes, and wide writes leave the command bits untouched. Other behaviour needs the bench scenarios. These are the exact read values of the reserved offsets and of wide reads, byte-lane placement and alignment of the pointer, the masking of command and status bits, and channel isolation. The bench also forces the same-cycle collision of a hardware set with a host clear.

// File: rtl/bmdma_pkg.sv
package bmdma_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int unsigned ST_ACT = 0;
  localparam int unsigned ST_ERR = 1;
  localparam int unsigned ST_IRQ = 2;
  localparam logic [7:0] ST_RW_MASK  = 8'h60;
  localparam logic [7:0] ST_W1C_MASK = 8'h06;
  localparam logic [7:0] CMD_MASK    = 8'h09;

  function automatic logic [31:0] size_mask(acc_size_e s);
    case (s)
      SZ_BYTE: size_mask = 32'h0000_00FF;
      SZ_HALF: size_mask = 32'h0000_FFFF;
      default: size_mask = 32'hFFFF_FFFF;
    endcase
  endfunction
endpackage

// File: rtl/bmdma_ptr.sv
module bmdma_ptr #(
  parameter int unsigned LANES = 4,
  parameter int unsigned ALIGN_BITS = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [LANES-1:0]   be_i,
  input  logic [LANES*8-1:0] wdata_i,
  output logic [LANES*8-1:0] ptr_o
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] lane_q;
    logic [7:0] keep;
    // lane 0 carries the alignment bits, tied low
    assign keep = (l == 0) ? ~8'((1 << ALIGN_BITS) - 1) : 8'hFF;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      lane_q <= '0;
      else if (be_i[l]) lane_q <= wdata_i[l*8 +: 8] & keep;
    end
    assign ptr_o[l*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/bmdma_chan.sv
module bmdma_chan
  import bmdma_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cs_we_i,
  input  logic [1:0]  cs_off_i,
  input  logic [7:0]  cs_wdata_i,
  input  logic [3:0]  ptr_be_i,
  input  logic [31:0] ptr_wdata_i,
  input  logic        set_act_i,
  input  logic        clr_act_i,
  input  logic        set_err_i,
  input  logic        set_irq_i,
  output logic [7:0]  cmd_o,
  output logic [7:0]  stat_o,
  output logic [31:0] ptr_o,
  output logic        irq_o
);
  logic [7:0] cmd_q, stat_q, stat_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          cmd_q <= '0;
    else if (cs_we_i && cs_off_i == 2'd0) cmd_q <= cs_wdata_i & CMD_MASK;
  end

  always_comb begin
    stat_d = stat_q;
    if (cs_we_i && cs_off_i == 2'd2)
      stat_d = (cs_wdata_i & ST_RW_MASK) | (stat_q & 8'h01) |
               (stat_q & ~cs_wdata_i & ST_W1C_MASK);
    if (set_act_i)      stat_d[ST_ACT] = 1'b1;
    else if (clr_act_i) stat_d[ST_ACT] = 1'b0;
    if (set_err_i)      stat_d[ST_ERR] = 1'b1;
    if (set_irq_i)      stat_d[ST_IRQ] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= stat_d;
  end

  bmdma_ptr #(.LANES(4), .ALIGN_BITS(2)) u_ptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .be_i    (ptr_be_i),
    .wdata_i (ptr_wdata_i),
    .ptr_o   (ptr_o)
  );

  assign cmd_o  = cmd_q;
  assign stat_o = stat_q;
  assign irq_o  = stat_q[ST_IRQ];

  // R7: host cannot move the active flag
  p_active_ro_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_act_i && !clr_act_i) |=> stat_q[ST_ACT] == $past(stat_q[ST_ACT]));
  // R8: hardware error set always lands
  p_err_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_err_i |=> stat_o[ST_ERR]);
  // R10: hardware interrupt set raises irq
  p_irq_set_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_irq_i |=> irq_o);
  // R7: write-one clears the interrupt flag when no set competes
  p_irq_w1c_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_we_i && cs_off_i == 2'd2 && cs_wdata_i[ST_IRQ] && !set_irq_i) |=> !irq_o);
endmodule

// File: rtl/bmdma_regs.sv
module bmdma_regs
  import bmdma_pkg::*;
#(
  parameter int unsigned N_CH = 2,
  localparam int unsigned CHW = $clog2(N_CH),
  localparam int unsigned AW  = CHW + 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [1:0]        size_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [N_CH-1:0]   set_active_i,
  input  logic [N_CH-1:0]   clr_active_i,
  input  logic [N_CH-1:0]   set_error_i,
  input  logic [N_CH-1:0]   set_irq_i,
  output logic [N_CH-1:0]   cmd_start_o,
  output logic [N_CH-1:0]   cmd_dir_o,
  output logic [N_CH*32-1:0] ptr_o,
  output logic [N_CH-1:0]   irq_o
);
  acc_size_e       sz;
  logic [CHW-1:0]  ch_sel;
  logic            ptr_half;
  logic [1:0]      off;
  logic [3:0]      be;
  logic [31:0]     ptr_wdata;

  assign sz       = acc_size_e'(size_i);
  assign ch_sel   = addr_i[AW-1:3];
  assign ptr_half = addr_i[2];
  assign off      = addr_i[1:0];

  always_comb begin
    case (sz)
      SZ_BYTE: begin be = 4'(1) << off;                  ptr_wdata = {4{wdata_i[7:0]}};  end
      SZ_HALF: begin be = off[1] ? 4'b1100 : 4'b0011;    ptr_wdata = {2{wdata_i[15:0]}}; end
      default: begin be = 4'b1111;                       ptr_wdata = wdata_i;            end
    endcase
  end

  logic [7:0]  cmd  [N_CH];
  logic [7:0]  stat [N_CH];
  logic [31:0] ptr  [N_CH];

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    logic hit;
    assign hit = req_i && we_i && (ch_sel == CHW'(i));
    bmdma_chan u_chan (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .cs_we_i     (hit && !ptr_half && sz == SZ_BYTE),
      .cs_off_i    (off),
      .cs_wdata_i  (wdata_i[7:0]),
      .ptr_be_i    ((hit && ptr_half) ? be : 4'b0000),
      .ptr_wdata_i (ptr_wdata),
      .set_act_i   (set_active_i[i]),
      .clr_act_i   (clr_active_i[i]),
      .set_err_i   (set_error_i[i]),
      .set_irq_i   (set_irq_i[i]),
      .cmd_o       (cmd[i]),
      .stat_o      (stat[i]),
      .ptr_o       (ptr[i]),
      .irq_o       (irq_o[i])
    );
    assign cmd_start_o[i]    = cmd[i][0];
    assign cmd_dir_o[i]      = cmd[i][3];
    assign ptr_o[i*32 +: 32] = ptr[i];
  end

  logic [1:0]  sh;
  logic [31:0] rd_val;

  always_comb begin
    case (sz)
      SZ_BYTE: sh = off;
      SZ_HALF: sh = {off[1], 1'b0};
      default: sh = 2'd0;
    endcase
    if (ptr_half) begin
      rd_val = (ptr[ch_sel] >> {sh, 3'b000}) & size_mask(sz);
    end else if (sz != SZ_BYTE) begin
      rd_val = size_mask(sz);
    end else begin
      case (off)
        2'd0:    rd_val = {24'h0, cmd[ch_sel]};
        2'd2:    rd_val = {24'h0, stat[ch_sel]};
        default: rd_val = 32'h0000_00FF;
      endcase
    end
  end

  assign rdata_o = (req_i && !we_i) ? rd_val : 32'h0;

  // R5: wide writes to the command/status sub-window leave commands alone
  p_wide_wr_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && !ptr_half && sz != SZ_BYTE)
      |=> (cmd_start_o == $past(cmd_start_o)) && (cmd_dir_o == $past(cmd_dir_o)));
endmodule

// File: tb/sim_bmdma_regs.sv
`timescale 1ns/1ps
module sim_bmdma_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req = 1'b0, we = 1'b0;
  logic [3:0]  addr = '0;
  logic [1:0]  size = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [1:0]  sa = '0, ca = '0, se = '0, si = '0;
  logic [1:0]  cstart, cdir, irq;
  logic [63:0] ptr;

  always #2.5 clk = ~clk;

  bmdma_regs u0 (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata),
    .set_active_i(sa), .clr_active_i(ca), .set_error_i(se), .set_irq_i(si),
    .cmd_start_o(cstart), .cmd_dir_o(cdir), .ptr_o(ptr), .irq_o(irq)
  );

  int errors = 0, checks = 0;
  bit done = 0;
  bit rd_act = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  task automatic chk(string req_tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req_tag, act, exp);
    end
  endtask

  // monitor: compares read data against the scoreboard
  always @(posedge clk) begin
    if (rd_act && exp_q.size() > 0) begin
      logic [31:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      chk(t, rdata, e);
    end
  end

  task automatic drive(logic r, logic w, logic [3:0] a, logic [1:0] s, logic [31:0] d,
                       logic [1:0] sa_v, logic [1:0] ca_v, logic [1:0] se_v, logic [1:0] si_v);
    @(negedge clk);
    req = r; we = w; addr = a; size = s; wdata = d;
    sa = sa_v; ca = ca_v; se = se_v; si = si_v;
    rd_act = 0;
  endtask

  task automatic idle();
    drive(0, 0, 4'h0, 2'd0, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic wr(logic [3:0] a, logic [1:0] s, logic [31:0] d);
    drive(1, 1, a, s, d, 2'b00, 2'b00, 2'b00, 2'b00);
  endtask

  task automatic rd(logic [3:0] a, logic [1:0] s, logic [31:0] exp, string t);
    drive(1, 0, a, s, 32'h0, 2'b00, 2'b00, 2'b00, 2'b00);
    exp_q.push_back(exp);
    tag_q.push_back(t);
    rd_act = 1;
  endtask

  task automatic hw(logic [1:0] sa_v, logic [1:0] ca_v, logic [1:0] se_v, logic [1:0] si_v);
    drive(0, 0, 4'h0, 2'd0, 32'h0, sa_v, ca_v, se_v, si_v);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    idle();
    chk("R1 irq", {30'h0, irq}, 32'h0);
    chk("R1 cmd outs", {28'h0, cstart, cdir}, 32'h0);
    rd(4'h0, 2'd0, 32'h0, "R1 cmd0");
    rd(4'h2, 2'd0, 32'h0, "R1 stat0");
    rd(4'h4, 2'd2, 32'h0, "R1 ptr0");
    rd(4'h8, 2'd0, 32'h0, "R1 cmd1");
    rd(4'hA, 2'd0, 32'h0, "R1 stat1");
    rd(4'hC, 2'd2, 32'h0, "R1 ptr1");

    wr(4'h0, 2'd0, 32'hFF);
    idle();
    chk("R6 start/dir", {28'h0, cstart, cdir}, 32'h5);
    rd(4'h0, 2'd0, 32'h09, "R6 cmd0 masked");
    rd(4'h8, 2'd0, 32'h00, "R2 cmd1 untouched");

    rd(4'h1, 2'd0, 32'hFF, "R3 off1 read");
    rd(4'hB, 2'd0, 32'hFF, "R3 off3 read");
    wr(4'h1, 2'd0, 32'hAA);
    wr(4'h3, 2'd0, 32'hFF);
    rd(4'h0, 2'd0, 32'h09, "R3 cmd0 after off1 write");
    rd(4'h2, 2'd0, 32'h00, "R3 stat0 after off3 write");

    rd(4'h0, 2'd1, 32'h0000FFFF, "R4 half read");
    rd(4'h8, 2'd2, 32'hFFFFFFFF, "R4 word read");
    rd(4'h2, 2'd3, 32'hFFFFFFFF, "R4 size3 read");

    wr(4'h0, 2'd1, 32'h0);
    wr(4'h0, 2'd2, 32'h0);
    wr(4'h2, 2'd2, 32'hFFFFFFFF);
    rd(4'h0, 2'd0, 32'h09, "R5 cmd0 after wide write");
    rd(4'h2, 2'd0, 32'h00, "R5 stat0 after wide write");

    wr(4'h2, 2'd0, 32'hFF);
    rd(4'h2, 2'd0, 32'h60, "R7 rw bits, active ro");

    hw(2'b01, 2'b00, 2'b01, 2'b01);
    idle();
    chk("R10 irq high", {30'h0, irq}, 32'h1);
    rd(4'h2, 2'd0, 32'h67, "R8 hw sets");

    wr(4'h2, 2'd0, 32'h66);
    idle();
    chk("R10 irq low", {30'h0, irq}, 32'h0);
    rd(4'h2, 2'd0, 32'h61, "R7 w1c keeps active");

    drive(1, 1, 4'hA, 2'd0, 32'h04, 2'b00, 2'b00, 2'b00, 2'b10);
    idle();
    chk("R8 set beats clear irq", {30'h0, irq}, 32'h2);
    rd(4'hA, 2'd0, 32'h04, "R8 stat1 after collision");

    hw(2'b00, 2'b01, 2'b00, 2'b00);
    rd(4'h2, 2'd0, 32'h60, "R8 clr active");
    hw(2'b01, 2'b01, 2'b00, 2'b00);
    rd(4'h2, 2'd0, 32'h61, "R8 set beats clr active");

    wr(4'h4, 2'd2, 32'h12345677);
    rd(4'h4, 2'd2, 32'h12345674, "R9 word write aligned");
    wr(4'h5, 2'd0, 32'hAB);
    rd(4'h4, 2'd2, 32'h1234AB74, "R9 byte lane 1");
    wr(4'h6, 2'd1, 32'hBEEF);
    rd(4'h4, 2'd2, 32'hBEEFAB74, "R9 half upper");
    rd(4'h7, 2'd0, 32'h000000BE, "R9 byte read lane 3");
    rd(4'h6, 2'd1, 32'h0000BEEF, "R9 half read");
    wr(4'h4, 2'd0, 32'h03);
    rd(4'h4, 2'd2, 32'hBEEFAB00, "R9 byte lane 0 aligned");
    wr(4'hC, 2'd2, 32'hFFFFFFFF);
    rd(4'hC, 2'd2, 32'hFFFFFFFC, "R9 ptr1");
    rd(4'h4, 2'd2, 32'hBEEFAB00, "R2 ptr0 isolated");
    idle();
    chk("R2 ptr port", ptr[63:32], 32'hFFFFFFFC);
    idle();

    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule